// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Front End

This block sits on the card side of a legacy 8-bit I/O expansion bus and tracks the auto-configuration protocol that a host runs through two fixed ports. One port is an index port at I/O 0x279. The other is a write-data port at I/O 0xA79. The block holds the card's protocol state, its card select number (CSN) and its selected logical device. It also holds the address of a relocatable read-data port, and it serves reads of the card-level registers through that port.

The card starts out dormant. It only listens for an unlock pattern written to the index port. Once unlocked it sleeps until a wake command names its CSN. It can then be isolated or configured. A self-clearing control register can send it back to dormancy, clear its CSN, or pulse a reset to the logical devices. A pointer into the card's resource description is brought out, so an external byte store can supply the resource data. The pointer steps once per resource-data read and is rewound by a successful wake.

Top module: `pnp_card_cfg`

## Requirements
- R1: After reset the state is Wait-for-Key (code 0). The CSN and the resource pointer are 0, `dev_rst` and `rd_oe` are low, and `rd_port` is 0x0003.
- R2: In Wait-for-Key, the card moves to Sleep (code 1) on the clock edge of the last of 32 consecutive index-port writes that match the key. The key's first byte is 0x6A, and each next byte is the previous one shifted right by one, with bit 7 filled by the XOR of the previous bits 0 and 1. A mismatching byte restarts the match, counting as the first byte only if it equals 0x6A.
- R3: In Wait-for-Key, data-port writes change neither the CSN nor `rd_port`.
- R4: A write to register 3 (wake) while in Sleep with data equal to the CSN moves the card to Isolation (code 2) if the data is 0, and to Config (code 3) otherwise. It also clears the resource pointer. With unequal data the card stays in Sleep.
- R5: A write to register 6 in Isolation loads the CSN and moves the card to Config. In Config the same write only loads the CSN.
- R6: A write to register 0 in Isolation or Config sets `rd_port` to {6'b0, data, 2'b11}.
- R7: Writing register 2 with bit 0 set, in Isolation or Config, raises `dev_rst` for exactly one cycle. CSN and state are kept, and nothing of the control value is stored.
- R8: Writing register 2 with bit 1 set, in Isolation or Config, returns the card to Wait-for-Key with the CSN kept.
- R9: Writing register 2 with bit 2 set, in Isolation or Config, clears the CSN to 0.
- R10: In Config, a read at address `rd_port` raises `rd_oe` and returns: 0x01 for register 5, the CSN for register 6, and the logical device for register 7. The logical device reads 0 with a single device, even after a write. A read at any other address leaves `rd_oe` low.
- R11: A read of register 4 in Config returns `res_data` for the current pointer, and the pointer then increments by one.
- R12: In Sleep, data-port writes other than wake change neither the CSN nor `rd_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Bus write strobe, one cycle per access |
| io_rd | input | 1 | Bus read strobe |
| io_addr | input | 16 | Bus I/O address |
| io_wdata | input | 8 | Bus write data |
| res_data | input | 8 | Resource byte at `res_ptr` from external store |
| rd_data | output | 8 | Read data, zero when not driving |
| rd_oe | output | 1 | Card drives the read data this cycle |
| rd_port | output | 16 | Current read-data port address |
| card_state | output | 2 | Protocol state: 0 key wait, 1 sleep, 2 isolation, 3 config |
| csn | output | 8 | Card select number |
| ldn | output | 8 | Selected logical device |
| res_ptr | output | PTR_W | Resource byte pointer |
| dev_rst | output | 1 | One-cycle logical device reset pulse |

## Verification
A wrong state code is visible on `card_state` one edge after the offending write. A state that lets writes through when it should not shows up as a changed `csn` or `rd_port` after the next data write. A key matcher that miscounts moves the card to Sleep one byte early or late, or never, and the bench checks the state both before and after the final key byte. A pointer error shows up on the very next resource read, because the external store returns a byte derived from the pointer.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  localparam logic [15:0] ADDR_PORT = 16'h0279;
  localparam logic [15:0] DATA_PORT = 16'h0A79;

  localparam logic [1:0] ST_WFK   = 2'd0;
  localparam logic [1:0] ST_SLEEP = 2'd1;
  localparam logic [1:0] ST_ISO   = 2'd2;
  localparam logic [1:0] ST_CFG   = 2'd3;

  localparam logic [7:0] REG_RDP  = 8'h00;
  localparam logic [7:0] REG_CTL  = 8'h02;
  localparam logic [7:0] REG_WAKE = 8'h03;
  localparam logic [7:0] REG_RES  = 8'h04;
  localparam logic [7:0] REG_STAT = 8'h05;
  localparam logic [7:0] REG_CSN  = 8'h06;
  localparam logic [7:0] REG_LDN  = 8'h07;

  localparam logic [7:0] KEY_SEED = 8'h6A;

  function automatic logic [7:0] key_next(input logic [7:0] b);
    return {b[0] ^ b[1], b[7:1]};
  endfunction

  function automatic logic [7:0] key_byte(input int idx);
    logic [7:0] b;
    b = KEY_SEED;
    for (int i = 0; i < 64; i++)
      if (i < idx) b = key_next(b);
    return b;
  endfunction

  function automatic logic [15:0] rd_port_of(input logic [7:0] bits);
    return {6'b0, bits, 2'b11};
  endfunction
endpackage

// File: rtl/pnp_key_match.sv
module pnp_key_match #(
  parameter int KEY_LEN = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       wr_addr,
  input  logic [7:0] wdata,
  output logic       key_done
);
  import pnp_cfg_pkg::*;
  localparam int IDX_W = $clog2(KEY_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_LEN - 1);

  logic [IDX_W-1:0] idx;
  logic             hit;

  assign hit      = (wdata == key_byte(int'(idx)));
  assign key_done = armed && wr_addr && hit && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !armed) idx <= '0;
    else if (wr_addr) begin
      if (hit) idx <= (idx == LAST) ? '0 : idx + 1'b1;
      else     idx <= (wdata == KEY_SEED) ? IDX_W'(1) : '0;
    end
  end
endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm #(
  parameter int NUM_LDN = 1,
  parameter int PTR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_done,
  input  logic             wr_addr,
  input  logic             wr_data,
  input  logic             rd_res,
  input  logic [7:0]       wdata,
  output logic [1:0]       state,
  output logic [7:0]       csn,
  output logic [7:0]       ldn,
  output logic [7:0]       rdp,
  output logic [7:0]       sel,
  output logic [PTR_W-1:0] ptr,
  output logic             dev_rst
);
  import pnp_cfg_pkg::*;
  logic active;
  assign active = (state == ST_ISO) || (state == ST_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_WFK; csn <= '0; rdp <= '0; sel <= '0; ptr <= '0; dev_rst <= 1'b0;
    end else begin
      dev_rst <= 1'b0;
      if (key_done && state == ST_WFK) state <= ST_SLEEP;
      if (wr_addr && state != ST_WFK) sel <= wdata;
      if (rd_res) ptr <= ptr + 1'b1;
      if (wr_data) begin
        case (sel)
          REG_RDP: if (active) rdp <= wdata;
          REG_CTL: if (active) begin
            if (wdata[0]) dev_rst <= 1'b1;
            if (wdata[2]) csn <= '0;
            if (wdata[1]) state <= ST_WFK;
          end
          REG_WAKE: if (state == ST_SLEEP && wdata == csn) begin
            state <= (wdata == 8'h00) ? ST_ISO : ST_CFG;
            ptr   <= '0;
          end
          REG_CSN: begin
            if (state == ST_ISO) begin csn <= wdata; state <= ST_CFG; end
            else if (state == ST_CFG) csn <= wdata;
          end
          default: ;
        endcase
      end
    end
  end

  generate
    if (NUM_LDN > 1) begin : g_multi
      logic [7:0] ldn_q;
      always_ff @(posedge clk) begin
        if (!rst_n) ldn_q <= '0;
        else if (wr_data && sel == REG_LDN && state == ST_CFG && 32'(wdata) < NUM_LDN)
          ldn_q <= wdata;
      end
      assign ldn = ldn_q;
    end else begin : g_single
      assign ldn = 8'h00;
    end
  endgenerate
endmodule

// File: rtl/pnp_read_mux.sv
module pnp_read_mux (
  input  logic [7:0] sel,
  input  logic [7:0] csn,
  input  logic [7:0] ldn,
  input  logic [7:0] res_data,
  output logic [7:0] dout
);
  import pnp_cfg_pkg::*;
  always_comb begin
    case (sel)
      REG_RES:  dout = res_data;
      REG_STAT: dout = 8'h01;
      REG_CSN:  dout = csn;
      REG_LDN:  dout = ldn;
      default:  dout = 8'h00;
    endcase
  end
endmodule

// File: rtl/pnp_card_cfg.sv
module pnp_card_cfg #(
  parameter int KEY_LEN = 32,
  parameter int NUM_LDN = 1,
  parameter int PTR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [15:0]      io_addr,
  input  logic [7:0]       io_wdata,
  input  logic [7:0]       res_data,
  output logic [7:0]       rd_data,
  output logic             rd_oe,
  output logic [15:0]      rd_port,
  output logic [1:0]       card_state,
  output logic [7:0]       csn,
  output logic [7:0]       ldn,
  output logic [PTR_W-1:0] res_ptr,
  output logic             dev_rst
);
  import pnp_cfg_pkg::*;

  logic       wr_addr_evt, wr_data_evt, rd_hit, rd_res, key_done;
  logic [7:0] sel_q, rdp_bits, mux_out;

  assign wr_addr_evt = io_wr && (io_addr == ADDR_PORT);
  assign wr_data_evt = io_wr && (io_addr == DATA_PORT);
  assign rd_port     = rd_port_of(rdp_bits);
  assign rd_hit      = io_rd && (io_addr == rd_port) && (card_state == ST_CFG);
  assign rd_res      = rd_hit && (sel_q == REG_RES);
  assign rd_oe       = rd_hit;
  assign rd_data     = rd_hit ? mux_out : 8'h00;

  pnp_key_match #(.KEY_LEN(KEY_LEN)) u_key (
    .clk(clk), .rst_n(rst_n), .armed(card_state == ST_WFK),
    .wr_addr(wr_addr_evt), .wdata(io_wdata), .key_done(key_done));

  pnp_card_fsm #(.NUM_LDN(NUM_LDN), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .key_done(key_done), .wr_addr(wr_addr_evt),
    .wr_data(wr_data_evt), .rd_res(rd_res), .wdata(io_wdata),
    .state(card_state), .csn(csn), .ldn(ldn), .rdp(rdp_bits), .sel(sel_q),
    .ptr(res_ptr), .dev_rst(dev_rst));

  pnp_read_mux u_mux (
    .sel(sel_q), .csn(csn), .ldn(ldn), .res_data(res_data), .dout(mux_out));
endmodule

// File: rtl/pnp_card_cfg_checker.sv
module pnp_card_cfg_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_done,
  input logic             wr_data_evt,
  input logic             rd_hit,
  input logic             rd_oe,
  input logic [7:0]       sel_q,
  input logic [7:0]       io_wdata,
  input logic [1:0]       card_state,
  input logic [7:0]       csn,
  input logic [PTR_W-1:0] res_ptr,
  input logic             dev_rst
);
  import pnp_cfg_pkg::*;
  logic act, ctl_wr;
  assign act    = (card_state == ST_ISO) || (card_state == ST_CFG);
  assign ctl_wr = wr_data_evt && act && sel_q == REG_CTL;

  p_key_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> card_state == ST_SLEEP);
  p_wfk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state == ST_WFK && wr_data_evt) |=> $stable(csn));
  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state == ST_SLEEP && wr_data_evt && sel_q == REG_WAKE && io_wdata == csn)
    |=> (card_state == (($past(io_wdata) == 8'h00) ? ST_ISO : ST_CFG)) && res_ptr == '0);
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> !dev_rst);
  p_to_wfk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && io_wdata[1] && !io_wdata[2]) |=> card_state == ST_WFK && $stable(csn));
  p_csn_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && io_wdata[2]) |=> csn == 8'h00);
  p_oe_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> card_state == ST_CFG);
  p_ptr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel_q == REG_RES && !wr_data_evt) |=> res_ptr == PTR_W'($past(res_ptr) + 1'b1));
endmodule

bind pnp_card_cfg pnp_card_cfg_checker #(.PTR_W(PTR_W)) u_chk (.*);

// File: tb/pnp_card_cfg_bench.sv
module pnp_card_cfg_bench;
  logic        clk = 0, rst_n = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0, res_data, rd_data, csn, ldn;
  logic        rd_oe, dev_rst;
  logic [15:0] rd_port;
  logic [1:0]  card_state;
  logic [7:0]  res_ptr;
  int checks = 0, errors = 0;
  logic [7:0] kb [32];
  logic [7:0] got;
  logic       got_oe;

  always #4 clk = ~clk;
  assign res_data = res_ptr ^ 8'h5C;

  pnp_card_cfg u_pnp_card_cfg (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic set_reg(input logic [7:0] r, input logic [7:0] v);
    wr(16'h0279, r); wr(16'h0A79, v);
  endtask

  task automatic rd_reg(input logic [7:0] r, input logic [15:0] a);
    wr(16'h0279, r);
    io_rd = 1; io_addr = a; #1;
    got = rd_data; got_oe = rd_oe;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic send_key(input int n);
    for (int i = 0; i < n; i++) wr(16'h0279, kb[i]);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [7:0] eptr;
    b = 8'h6A;
    for (int i = 0; i < 32; i++) begin
      kb[i] = b;
      b = (b >> 1) | (((b ^ (b >> 1)) & 8'h01) << 7);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 state", card_state, 0); chk("R1 csn", csn, 0);
    chk("R1 rd_port", rd_port, 16'h0003); chk("R1 ptr", res_ptr, 0);
    chk("R1 dev_rst", dev_rst, 0); chk("R1 rd_oe", rd_oe, 0);
    // R3 ignored in key wait
    set_reg(8'h06, 8'h55); chk("R3 csn", csn, 0); chk("R3 state", card_state, 0);
    set_reg(8'h00, 8'h80); chk("R3 rd_port", rd_port, 16'h0003);
    // R2 key matching with restart
    send_key(10); wr(16'h0279, 8'h00);
    send_key(31); chk("R2 before last", card_state, 0);
    wr(16'h0279, kb[31]); chk("R2 sleep", card_state, 1);
    // R12 sleep ignores non-wake
    set_reg(8'h06, 8'h12); chk("R12 csn", csn, 0);
    set_reg(8'h00, 8'h44); chk("R12 rd_port", rd_port, 16'h0003);
    // R4 wake
    set_reg(8'h03, 8'h05); chk("R4 mismatch", card_state, 1);
    set_reg(8'h03, 8'h00); chk("R4 to iso", card_state, 2);
    // R5 set csn
    set_reg(8'h06, 8'h07); chk("R5 csn", csn, 7); chk("R5 cfg", card_state, 3);
    // R6 read port sweep
    for (int v = 0; v < 256; v += 37) begin
      set_reg(8'h00, 8'(v));
      chk("R6 rd_port", rd_port, {6'b0, 8'(v), 2'b11});
    end
    set_reg(8'h00, 8'h81);
    // R10 register reads
    rd_reg(8'h05, 16'h0207); chk("R10 status", got, 1); chk("R10 oe", got_oe, 1);
    rd_reg(8'h06, 16'h0207); chk("R10 csn", got, 7);
    set_reg(8'h07, 8'h05);
    rd_reg(8'h07, 16'h0207); chk("R10 ldn", got, 0);
    rd_reg(8'h06, 16'h0203); chk("R10 other addr oe", got_oe, 0);
    // R11 resource reads
    eptr = 0;
    for (int i = 0; i < 5; i++) begin
      rd_reg(8'h04, 16'h0207);
      chk("R11 data", got, eptr ^ 8'h5C);
      eptr++;
      chk("R11 ptr", res_ptr, eptr);
    end
    // R7 device reset pulse
    set_reg(8'h02, 8'h01);
    chk("R7 pulse", dev_rst, 1); chk("R7 csn", csn, 7); chk("R7 state", card_state, 3);
    @(negedge clk); chk("R7 clear", dev_rst, 0);
    // R9 csn clear
    set_reg(8'h02, 8'h04); chk("R9 csn", csn, 0); chk("R9 state", card_state, 3);
    set_reg(8'h06, 8'h09); chk("R5 cfg csn", csn, 9);
    // R8 back to key wait
    set_reg(8'h02, 8'h02); chk("R8 state", card_state, 0); chk("R8 csn", csn, 9);
    // R4 wake to config rewinds pointer
    send_key(32); chk("R2 sleep again", card_state, 1);
    set_reg(8'h03, 8'h09); chk("R4 to cfg", card_state, 3); chk("R4 ptr", res_ptr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule